// File: doc/BRIEF.md
# Lockable Prescaled Interval Timer

A 32-bit down-counting interval timer with a separate clock prescaler. It sits on a simple word-wide register bus with chip select, write enable, word address, write data, read data and a ready strobe. Software loads a prescaler value and a timer count while the timer is idle, then sets a start bit. While the timer runs, the prescaler divides the clock: a prescaler value of P makes the count drop by one every P+1 clock cycles. When the count reaches zero, the timer halts by itself.

While it runs, the configuration is locked. Writes to the prescaler and to the count are dropped, and a second start command does nothing. The count register serves two purposes: it holds the value to be loaded when the timer is idle, and it returns the live count during a run. A stop command freezes the count where it is. A later start resumes from that frozen value with a fresh prescaler phase.

The register map uses word addresses. Address 0 is control: bit 0 is start and bit 1 is stop. Address 1 is status: bit 0 is the running flag. Address 2 is the prescaler value and address 3 is the count. Any address with a bit set above bit 1 is unmapped.

Top module: `lockable_timer`

## Requirements
- R1: While the active-low synchronous reset is held, ready is 0. After reset, the status, prescaler and count registers all read 0.
- R2: Writing control (word 0) with bit 0 set while stopped and with a non-zero count starts a run. If the start write is captured on clock edge S, a read captured on edge R returns count C - floor(k/(P+1)) and status 0x1, where k = R-1-S, C is the count and P is the prescaler.
- R3: A start command written while the timer is running has no effect on the count sequence or the running flag.
- R4: Writing control with bit 1 set while running stops the timer on that edge. The count freezes at its current value and status reads 0. A stop written while stopped has no effect, and a write with both bits set while stopped starts a run.
- R5: Writes to the prescaler (word 2) are accepted only while stopped. Writes made during a run are dropped.
- R6: Writes to the count (word 3) are accepted only while stopped. Writes made during a run are dropped, and a write while stopped sets the value read back and the value a later start runs from.
- R7: When k reaches C*(P+1), the running flag clears by itself and the count reads 0.
- R8: A start command while the count is 0 is refused, and status stays 0.
- R9: Ready is 1 in the cycle after every chip-select access, read or write, and 0 after a cycle without chip select.
- R10: Reads of control and of unmapped addresses return 0. Writes to unmapped addresses change no register. Status returns the running flag in bit 0 with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Chip select for one bus access |
| wrEn | input | 1 | 1 = write access, 0 = read access |
| addr | input | ADDR_W | Word address |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data, valid while ready is 1 |
| ready | output | 1 | Access completed, one cycle after select |

## Verification
The bench sweeps small prescaler and count values and polls the live count and the status through the bus. Each read is checked against the arithmetic count for its capture edge, so an off-by-one in the prescaler reload or in the expiry edge shows up as a wrong count or a late running flag. It writes the prescaler, the count and a second start during a run; a design without the write lock would read back the new values or restart the sequence. It also covers the following:
- a stop written mid-run and then held, where a design that keeps decrementing would show a drifting count;
- a start with a zero count, which a design would wrongly accept and leave running;
- a combined start-and-stop write while idle;
- unmapped accesses.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Word offsets within the register window; upper address bits must be zero.
  typedef enum logic [1:0] {
    RegCtrl  = 2'd0,
    RegStat  = 2'd1,
    RegPre   = 2'd2,
    RegCount = 2'd3
  } regSel_e;

  localparam int unsigned CTRL_START_BIT = 0;
  localparam int unsigned CTRL_STOP_BIT  = 1;
  localparam int unsigned STAT_RUN_BIT   = 0;
  localparam int unsigned CMD_W          = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrPre;    // accept a prescaler write
    logic wrCount;  // accept a count write
    logic arm;      // a run begins: load the prescaler phase
    logic step;     // advance the counters this cycle
  } dpStrobe_t;

endpackage

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] preVal,
  output logic [DATA_W-1:0] countVal,
  output logic              preCntIsZero,
  output logic              countIsZero,
  output logic              countIsOne
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] preCnt;
  logic              tick;

  assign tick         = stb.step && (preCnt == '0);
  assign preCntIsZero = (preCnt == '0);
  assign countIsZero  = (countVal == '0);
  assign countIsOne   = (countVal == ONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preVal <= '0;
    end else if (stb.wrPre) begin
      preVal <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (stb.arm) begin
      preCnt <= preVal;
    end else if (stb.step) begin
      preCnt <= (preCnt == '0) ? preVal : preCnt - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countVal <= '0;
    end else if (stb.wrCount) begin
      countVal <= wrData;
    end else if (tick) begin
      countVal <= countVal - ONE;
    end
  end

  // R7: the counters only advance while a non-zero count is left
  step_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.step |-> (countVal != '0));

  // R5
  no_cfg_race_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wrPre && stb.step));

endmodule

// File: rtl/tmr_control.sv
module tmr_control
  import tmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sel,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CMD_W-1:0]  cmdBits,
  input  logic [DATA_W-1:0] preVal,
  input  logic [DATA_W-1:0] countVal,
  input  logic              preCntIsZero,
  input  logic              countIsZero,
  input  logic              countIsOne,
  output dpStrobe_t         stb,
  output logic [DATA_W-1:0] rdData,
  output logic              ready
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic              running;
  logic              hit;
  regSel_e           idx;
  logic              ctrlWr;
  logic              startOk;
  logic              stopOk;
  logic              expire;
  logic [DATA_W-1:0] rdNext;

  assign hit     = sel && ((addr >> 2) == '0);
  assign idx     = regSel_e'(addr[1:0]);
  assign ctrlWr  = hit && wrEn && (idx == RegCtrl);
  assign startOk = ctrlWr && cmdBits[CTRL_START_BIT] && !running && !countIsZero;
  assign stopOk  = ctrlWr && cmdBits[CTRL_STOP_BIT] && running;
  assign expire  = running && !stopOk && preCntIsZero && countIsOne;

  always_comb begin
    stb         = '0;
    stb.wrPre   = hit && wrEn && (idx == RegPre) && !running;
    stb.wrCount = hit && wrEn && (idx == RegCount) && !running;
    stb.arm     = startOk;
    stb.step    = running && !stopOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
    end else if (startOk) begin
      running <= 1'b1;
    end else if (stopOk || expire) begin
      running <= 1'b0;
    end
  end

  always_comb begin
    rdNext = '0;
    if (hit) begin
      unique case (idx)
        RegStat:  rdNext[STAT_RUN_BIT] = running;
        RegPre:   rdNext = preVal;
        RegCount: rdNext = countVal;
        default:  rdNext = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ready  <= 1'b0;
      rdData <= '0;
    end else begin
      ready  <= sel;
      rdData <= (sel && !wrEn) ? rdNext : '0;
    end
  end

  // R9
  ready_after_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    sel |=> ready);

  // R9
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sel |=> !ready);

  // R5
  pre_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    running |=> $stable(preVal));

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    running |=> (countVal == $past(countVal)) || (countVal == $past(countVal) - ONE));

  // R7
  run_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    running |-> !countIsZero);

  // R8
  zero_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!running && countIsZero) |=> !running);

  // R4
  stop_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopOk |=> !running && $stable(countVal));

endmodule

// File: rtl/lockable_timer.sv
module lockable_timer
  import tmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sel,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              ready
);

  dpStrobe_t         stb;
  logic [DATA_W-1:0] preVal;
  logic [DATA_W-1:0] countVal;
  logic              preCntIsZero;
  logic              countIsZero;
  logic              countIsOne;

  tmr_control #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .sel          (sel),
    .wrEn         (wrEn),
    .addr         (addr),
    .cmdBits      (wrData[CMD_W-1:0]),
    .preVal       (preVal),
    .countVal     (countVal),
    .preCntIsZero (preCntIsZero),
    .countIsZero  (countIsZero),
    .countIsOne   (countIsOne),
    .stb          (stb),
    .rdData       (rdData),
    .ready        (ready)
  );

  tmr_datapath #(.DATA_W(DATA_W)) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .wrData       (wrData),
    .preVal       (preVal),
    .countVal     (countVal),
    .preCntIsZero (preCntIsZero),
    .countIsZero  (countIsZero),
    .countIsOne   (countIsOne)
  );

endmodule

// File: tb/tb_lockable_timer.sv
module tb_lockable_timer;

  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              sel = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic              ready;

  int edgeNo = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  lockable_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rstN(rstN), .sel(sel), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .ready(ready)
  );

  always #4 clk = ~clk;
  always @(posedge clk) edgeNo <= edgeNo + 1;

  always @(posedge clk) begin
    if (edgeNo > 150000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", edgeNo);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic we, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                      output logic [DATA_W-1:0] q, output int cap);
    @(negedge clk);
    sel = 1'b1; wrEn = we; addr = a; wrData = d;
    @(negedge clk);
    cap = edgeNo;
    q = rdData;
    chk(ready == 1'b1, "R9 ready after access", longint'(ready), 1);
    sel = 1'b0; wrEn = 1'b0; wrData = '0;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, output int cap);
    logic [DATA_W-1:0] q;
    xfer(1'b1, a, d, q, cap);
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] q, output int cap);
    xfer(1'b0, a, '0, q, cap);
  endtask

  function automatic longint expCount(input longint t, input longint p, input longint k);
    if (k >= t * (p + 1)) return 0;
    return t - k / (p + 1);
  endfunction

  initial begin
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] st;
    int c, s, x;
    longint frozen;

    repeat (3) @(negedge clk);
    chk(ready == 1'b0, "R1 ready in reset", longint'(ready), 0);
    rstN = 1'b1;

    rd(4'd1, q, c); chk(q == 0, "R1 status after reset", q, 0);
    rd(4'd2, q, c); chk(q == 0, "R1 prescaler after reset", q, 0);
    rd(4'd3, q, c); chk(q == 0, "R1 count after reset", q, 0);
    @(negedge clk);
    chk(ready == 1'b0, "R9 ready idle", longint'(ready), 0);

    // R10: unmapped and control reads, unmapped write
    rd(4'd5, q, c); chk(q == 0, "R10 unmapped read", q, 0);
    rd(4'd0, q, c); chk(q == 0, "R10 control read", q, 0);
    wr(4'd6, 32'h55, c);
    rd(4'd2, q, c); chk(q == 0, "R10 unmapped write", q, 0);

    // R8: start with zero count refused
    wr(4'd0, 32'h1, c);
    rd(4'd1, q, c); chk(q == 0, "R8 zero-count start", q, 0);

    // R2 / R7 sweep
    for (int p = 0; p < 4; p++) begin
      for (int t = 1; t < 4; t++) begin
        wr(4'd2, DATA_W'(p), c);
        wr(4'd3, DATA_W'(t), c);
        wr(4'd0, 32'h1, s);
        st = 1;
        for (int g = 0; g < 40 && st != 0; g++) begin
          rd(4'd3, q, c);
          chk(q == expCount(t, p, c - 1 - s), "R2 live count", q, expCount(t, p, c - 1 - s));
          rd(4'd1, st, c);
          chk(st == ((c - 1 - s) < t * (p + 1) ? 1 : 0), "R2/R7 status", st,
              ((c - 1 - s) < t * (p + 1) ? 1 : 0));
        end
        rd(4'd3, q, c); chk(q == 0, "R7 count after expiry", q, 0);
      end
    end

    // R3 / R5 / R6: locked during a run
    wr(4'd2, 32'd2, c);
    wr(4'd3, 32'd5, c);
    wr(4'd0, 32'h1, s);
    wr(4'd2, 32'd9, c);
    wr(4'd3, 32'd77, c);
    wr(4'd0, 32'h1, c);
    rd(4'd2, q, c); chk(q == 2, "R5 prescaler locked", q, 2);
    rd(4'd3, q, c);
    chk(q == expCount(5, 2, c - 1 - s), "R6/R3 count unaffected", q, expCount(5, 2, c - 1 - s));

    // R4: stop freezes
    wr(4'd0, 32'h2, x);
    frozen = expCount(5, 2, x - 1 - s);
    rd(4'd3, q, c); chk(q == frozen, "R4 frozen count", q, frozen);
    repeat (10) @(negedge clk);
    rd(4'd3, q, c); chk(q == frozen, "R4 count held", q, frozen);
    rd(4'd1, q, c); chk(q == 0, "R4 status after stop", q, 0);
    wr(4'd0, 32'h2, c);
    rd(4'd1, q, c); chk(q == 0, "R4 stop while stopped", q, 0);
    rd(4'd3, q, c); chk(q == frozen, "R4 stop while stopped count", q, frozen);

    // R6: write while stopped accepted; R4: both bits while stopped starts
    wr(4'd3, 32'd3, c);
    rd(4'd3, q, c); chk(q == 3, "R6 write while stopped", q, 3);
    wr(4'd0, 32'h3, s);
    rd(4'd1, q, c); chk(q == 1, "R4 start+stop while stopped", q, 1);
    rd(4'd3, q, c);
    chk(q == expCount(3, 2, c - 1 - s), "R6 resume count", q, expCount(3, 2, c - 1 - s));
    repeat (12) @(negedge clk);
    rd(4'd1, q, c); chk(q == 0, "R7 resumed run expired", q, 0);
    rd(4'd3, q, c); chk(q == 0, "R7 resumed count zero", q, 0);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule